// File: doc/BRIEF.md
# MDIO Management Master

This block lets software run one management transaction at a time against an external Ethernet PHY over the two-wire MDC/MDIO interface. Software loads a control word with the PHY address, the PHY register address, a direction flag and a code describing the range of the system clock frequency. Setting the busy bit in that word starts the transaction. For a write, the 16-bit value is loaded into the data register first.

The block divides the system clock down to MDC by a ratio chosen from the range code. It shifts out a 64-bit management frame MSB first and changes MDIO only after MDC falls. For a read it releases the line during the turnaround and the data phase, and it samples the PHY's bits when MDC rises. When the last bit is done, any read value is placed in the data register and busy drops to zero. Software polls busy to detect completion.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control readback, the data readback, MDC and the MDIO output enable are all zero.
- R2: Range code in control bits [4:2] sets the MDC period in system clocks: 0→16, 1→26, 2→42, 3→62, 4→102, 5/6/7→124. A transaction keeps busy high for exactly 64 MDC periods.
- R3: Control layout: bit 0 busy, bit 1 write (1 = write, 0 = read), bits [4:2] range, bits [10:6] register address, bits [15:11] PHY address. The other bits read as zero, and accepted fields read back unchanged.
- R4: A write frame is 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data-register bits, every field MSB first.
- R5: A read frame drives 32 ones, start 01, opcode 10, PHY address and register address. The output enable is low for the 2 turnaround bits and the 16 data bits.
- R6: Read data is sampled on MDC rising edges during the data phase. It appears MSB first in data register bits [15:0] when busy clears, and bits [31:16] read as zero.
- R7: MDIO output changes only on an MDC falling edge. While idle, MDC is low and the output enable is low.
- R8: MDC makes exactly 64 rising edges per transaction, and busy clears by itself after the last bit.
- R9: A control write while busy updates only the range field. Direction, addresses and busy keep their values, and the MDC rate of the running transaction does not change.
- R10: A data-register write while busy is ignored, so a write frame sends the value loaded before the start.
- R11: A control write with bit 0 clear updates the fields but starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control register, 1 selects data register |
| reg_wdata | input | 32 | Register write value |
| ctrl_rdata | output | 32 | Control register readback |
| data_rdata | output | 32 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A wrong bit counter or frame select shows at the pins within one MDC period, as a misplaced field in the captured bit stream or a wrong number of MDC edges. A wrong divider or a divider that takes the range update mid-transaction changes how long busy stays high, so it shows by the cycle at the end of the frame. A lost or misplaced read sample shows in the data readback at the moment busy clears. A guard failure on writes during busy shows as altered readback fields or an altered frame during that same transaction.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int RANGE_W = 3;
   localparam int HALF_W  = 6;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_DATA = 1'b1
   } mdio_sel_e;

   // half of the MDC period, in system clocks, for each range code
   function automatic logic [HALF_W-1:0] half_period(input logic [RANGE_W-1:0] code);
      case (code)
         3'd0:    half_period = 6'd8;
         3'd1:    half_period = 6'd13;
         3'd2:    half_period = 6'd21;
         3'd3:    half_period = 6'd31;
         3'd4:    half_period = 6'd51;
         default: half_period = 6'd62;
      endcase
   endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
   parameter int HALF_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half,
   output logic              mdc,
   output logic              rise,
   output logic              fall
);

   logic [HALF_W-1:0] cnt;
   logic              tick;

   assign tick = run && (cnt == half - 1'b1);
   assign rise = tick && !mdc;
   assign fall = tick && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R7: MDC only starts toggling while a transaction runs
   a_r7_mdc_rise_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> run);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
   parameter int FRAME_LEN = 64,
   parameter int TA_POS    = 46,
   parameter int DW        = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 rise,
   input  logic                 fall,
   input  logic                 is_write,
   input  logic [FRAME_LEN-1:0] frame,
   input  logic                 din,
   output logic                 dout,
   output logic                 oe,
   output logic                 done,
   output logic [DW-1:0]        rd_data
);

   localparam int IDX_W = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
   localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(TA_POS + 2);

   logic [IDX_W-1:0] idx;
   logic [DW-1:0]    rd_sh;

   assign done    = run && fall && (idx == LAST_IDX);
   assign dout    = frame[LAST_IDX - idx];
   assign oe      = run && (is_write || (idx < TA_IDX));
   assign rd_data = rd_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (!run) begin
         idx <= '0;
      end else if (fall && (idx != LAST_IDX)) begin
         idx <= idx + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_sh <= '0;
      end else if (run && rise && !is_write && (idx >= DATA_IDX)) begin
         rd_sh <= {rd_sh[DW-2:0], din};
      end
   end

   // R7: a driven MDIO bit only moves on a falling MDC edge
   a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && oe && $past(oe) && (dout != $past(dout))) |-> $past(fall));

   // R5: the driver is released mid-frame only for a read
   a_r5_release_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(oe) && run) |-> !is_write);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN     = 32,
   parameter int AW          = 5,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic        reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] ctrl_rdata,
   output logic [31:0] data_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   localparam int TA_POS    = PRE_LEN + 4 + 2 * AW;
   localparam int FRAME_LEN = TA_POS + 2 + DW;

   // elaboration checks
   if (AW != 5) begin : g_bad_aw
      $error("address fields are fixed at 5 bits");
   end
   if (DW != 16) begin : g_bad_dw
      $error("data field is fixed at 16 bits");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("preamble needs at least one bit");
   end
   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("at most 3 input synchroniser stages");
   end

   logic                busy_q;
   logic                wr_q;
   logic [RANGE_W-1:0]  range_q;
   logic [AW-1:0]       regad_q;
   logic [AW-1:0]       phy_q;
   logic [DW-1:0]       data_q;
   logic [HALF_W-1:0]   half_q;

   logic                rise, fall, seq_done;
   logic [DW-1:0]       rd_data;
   logic [FRAME_LEN-1:0] frame;
   logic                din_s;
   logic                wr_ctrl, wr_data;
   logic                unused_ok;

   assign unused_ok = ^{reg_wdata[31:16], reg_wdata[5]};
   assign wr_ctrl   = reg_wr_en && (reg_sel == SEL_CTRL);
   assign wr_data   = reg_wr_en && (reg_sel == SEL_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         wr_q    <= 1'b0;
         range_q <= '0;
         regad_q <= '0;
         phy_q   <= '0;
         data_q  <= '0;
         half_q  <= '1;
      end else begin
         if (seq_done) begin
            busy_q <= 1'b0;
            if (!wr_q) data_q <= rd_data;
         end
         if (wr_ctrl) begin
            range_q <= reg_wdata[4:2];
            if (!busy_q) begin
               wr_q    <= reg_wdata[1];
               regad_q <= reg_wdata[10:6];
               phy_q   <= reg_wdata[15:11];
               busy_q  <= reg_wdata[0];
               if (reg_wdata[0]) half_q <= half_period(reg_wdata[4:2]);
            end
         end else if (wr_data && !busy_q) begin
            data_q <= reg_wdata[DW-1:0];
         end
      end
   end

   assign ctrl_rdata = {16'b0, phy_q, regad_q, 1'b0, range_q, wr_q, busy_q};
   assign data_rdata = {{(32-DW){1'b0}}, data_q};

   assign frame = {{PRE_LEN{1'b1}}, 2'b01, (wr_q ? 2'b01 : 2'b10),
                   phy_q, regad_q, (wr_q ? 2'b10 : 2'b11), data_q};

   // input synchroniser, chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign din_s = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
         end else begin
            chain[0] <= mdio_i;
            for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
         end
      end
      assign din_s = chain[SYNC_STAGES-1];
   end

   mdio_clk_gen #(.HALF_W(HALF_W)) u_clk (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy_q),
      .half (half_q),
      .mdc  (mdc),
      .rise (rise),
      .fall (fall)
   );

   mdio_frame_seq #(.FRAME_LEN(FRAME_LEN), .TA_POS(TA_POS), .DW(DW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy_q),
      .rise    (rise),
      .fall    (fall),
      .is_write(wr_q),
      .frame   (frame),
      .din     (din_s),
      .dout    (mdio_o),
      .oe      (mdio_oe),
      .done    (seq_done),
      .rd_data (rd_data)
   );

   // R7: MDC rests low while idle
   a_r7_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !mdc);

   // R8: the end of the frame clears busy
   a_r8_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !busy_q);

   // R9: control writes during a transaction leave the frame fields alone
   a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && wr_ctrl) |=> ($stable(phy_q) && $stable(regad_q) && $stable(wr_q) && $stable(half_q)));

   // R10: data writes during a transaction are dropped
   a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && wr_data && !seq_done) |=> $stable(data_q));

endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] ctrl_rdata, data_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_mgmt_master u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // vector: [29] write, [28:26] range, [25:21] phy, [20:16] reg, [15:0] data
   localparam logic [29:0] VEC [6] = '{
      {1'b1, 3'd0, 5'h01, 5'h00, 16'hA5C3},
      {1'b0, 3'd0, 5'h1F, 5'h1F, 16'h8001},
      {1'b1, 3'd1, 5'h10, 5'h05, 16'hFFFF},
      {1'b0, 3'd2, 5'h03, 5'h11, 16'h7E81},
      {1'b1, 3'd3, 5'h00, 5'h00, 16'h0000},
      {1'b0, 3'd0, 5'h15, 5'h0A, 16'hFFFF}
   };

   // PHY-side capture and drive
   int          rcnt = 0;
   logic        cap_o  [64];
   logic        cap_oe [64];
   logic [15:0] phy_val = '0;
   int          bcnt = 0;
   int          viol = 0;
   logic        prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;

   always @(posedge mdc) begin
      if (rcnt < 64) begin
         cap_o[rcnt]  = mdio_o;
         cap_oe[rcnt] = mdio_oe;
      end
      rcnt = rcnt + 1;
   end

   always @(negedge mdc) begin
      if (rcnt >= 48 && rcnt < 64) mdio_i = phy_val[15 - (rcnt - 48)];
      else mdio_i = 1'b1;
   end

   always @(negedge clk) begin
      if (ctrl_rdata[0]) bcnt = bcnt + 1;
      if (mdio_oe && prev_oe && (mdio_o != prev_o) && !(prev_mdc && !mdc)) viol = viol + 1;
      prev_mdc = mdc;
      prev_o   = mdio_o;
      prev_oe  = mdio_oe;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [31:0] val);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_sel   = sel;
      reg_wdata = val;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   function automatic int period_of(input logic [2:0] code);
      case (code)
         3'd0: return 16;
         3'd1: return 26;
         3'd2: return 42;
         3'd3: return 62;
         3'd4: return 102;
         default: return 124;
      endcase
   endfunction

   function automatic logic [31:0] ctrl_word(input logic wr, input logic [2:0] rng,
                                             input logic [4:0] phy, input logic [4:0] ra, input logic go);
      return {16'b0, phy, ra, 1'b0, rng, wr, go};
   endfunction

   task automatic wait_idle();
      while (ctrl_rdata[0]) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic start_txn(input logic wr, input logic [2:0] rng, input logic [4:0] phy,
                            input logic [4:0] ra, input logic [15:0] d);
      if (wr) wr_reg(1'b1, {16'b0, d});
      phy_val = d;
      rcnt = 0;
      viol = 0;
      bcnt = 0;
      wr_reg(1'b0, ctrl_word(wr, rng, phy, ra, 1'b1));
   endtask

   task automatic check_frame(input logic wr, input logic [4:0] phy, input logic [4:0] ra,
                              input logic [15:0] d);
      logic [63:0] exp;
      int          errs = 0;
      int          oerr = 0;
      exp = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, d};
      for (int k = 0; k < 64; k++) begin
         if (wr || k < 46) begin
            if (cap_o[k] !== exp[63-k]) errs++;
            if (cap_oe[k] !== 1'b1) oerr++;
         end else if (cap_oe[k] !== 1'b0) oerr++;
      end
      if (wr) chk(errs == 0, "R4 write frame bits", errs, 0);
      else    chk(errs == 0, "R5 read frame header bits", errs, 0);
      chk(oerr == 0, "R5 output enable pattern", oerr, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [29:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ctrl_rdata == 0, "R1 ctrl after reset", ctrl_rdata, 0);
      chk(data_rdata == 0, "R1 data after reset", data_rdata, 0);
      chk(!mdc && !mdio_oe, "R1 mdc/oe after reset", {mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk
      for (int i = 0; i < 6; i++) begin
         v = VEC[i];
         start_txn(v[29], v[28:26], v[25:21], v[20:16], v[15:0]);
         wait_idle();
         check_frame(v[29], v[25:21], v[20:16], v[15:0]);
         chk(bcnt == 64 * period_of(v[28:26]), "R2 busy duration", bcnt, 64 * period_of(v[28:26]));
         chk(rcnt == 64, "R8 MDC rising edges", rcnt, 64);
         chk(viol == 0, "R7 MDIO change off falling edge", viol, 0);
         chk(!mdc && !mdio_oe, "R7 idle line state", {mdc, mdio_oe}, 0);
         chk(data_rdata == {16'b0, v[15:0]}, "R6 data register after transaction", data_rdata, {16'b0, v[15:0]});
         chk(ctrl_rdata == ctrl_word(v[29], v[28:26], v[25:21], v[20:16], 1'b0),
             "R3 ctrl readback after done", ctrl_rdata, ctrl_word(v[29], v[28:26], v[25:21], v[20:16], 1'b0));
      end

      // R2 remaining range codes
      for (int c = 4; c < 8; c++) begin
         start_txn(1'b0, 3'(c), 5'h02, 5'h01, 16'h1357);
         wait_idle();
         chk(bcnt == 64 * period_of(3'(c)), "R2 busy duration high range", bcnt, 64 * period_of(3'(c)));
         chk(data_rdata == 32'h0000_1357, "R6 read value", data_rdata, 32'h0000_1357);
      end

      // R9 and R10: writes during a running write transaction
      start_txn(1'b1, 3'd0, 5'h02, 5'h03, 16'h1234);
      repeat (100) @(negedge clk);
      wr_reg(1'b0, ctrl_word(1'b0, 3'd3, 5'h1F, 5'h1F, 1'b1));
      wr_reg(1'b1, 32'h0000_DEAD);
      chk(ctrl_rdata == ctrl_word(1'b1, 3'd3, 5'h02, 5'h03, 1'b1), "R9 ctrl during busy",
          ctrl_rdata, ctrl_word(1'b1, 3'd3, 5'h02, 5'h03, 1'b1));
      wait_idle();
      chk(bcnt == 64 * 16, "R9 rate unchanged mid-transaction", bcnt, 64 * 16);
      check_frame(1'b1, 5'h02, 5'h03, 16'h1234);
      chk(data_rdata == 32'h0000_1234, "R10 data write ignored while busy", data_rdata, 32'h0000_1234);

      // R11: busy bit clear starts nothing
      rcnt = 0;
      bcnt = 0;
      wr_reg(1'b0, ctrl_word(1'b1, 3'd0, 5'h0C, 5'h06, 1'b0));
      repeat (300) @(negedge clk);
      chk(rcnt == 0 && bcnt == 0, "R11 no transaction without busy", rcnt + bcnt, 0);
      chk(ctrl_rdata == ctrl_word(1'b1, 3'd0, 5'h0C, 5'h06, 1'b0), "R3 R11 field update",
          ctrl_rdata, ctrl_word(1'b1, 3'd0, 5'h0C, 5'h06, 1'b0));
      chk(ctrl_rdata[31:16] == 0 && ctrl_rdata[5] == 0, "R3 reserved bits zero", ctrl_rdata, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule